// File: doc/BRIEF.md
# Dual-Width Integer ALU Execution Unit

This block is the arithmetic and logic stage of a 64-bit register machine. Each beat carries one decoded 8-bit opcode together with the current destination register value, the source register value and a 32-bit immediate. The unit computes the new value for the destination register and presents it one clock later. Instruction fetch, register storage and exception reporting belong to the surrounding pipeline.

The opcode has three fields. The low three bits give the class: a 64-bit class that works on full register values, and a 32-bit class that works on the low halves and zero-extends its result. The next bit picks the second operand, either the immediate or the source register. The top four bits pick the operation. An opcode the unit cannot execute raises a flag with that beat's result and passes the destination value through unchanged.

The input side and the output side each use a valid/ready handshake. One output register holds the result. A new beat is taken whenever that register is empty or is being drained in the same cycle.

Top module: `dw_alu_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit clears `out_valid` and `out_illegal` at that edge, and `in_ready` is high once reset is released.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat taken at one edge shows up on `out_valid`/`out_result` right after that edge. While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` hold steady.
- R3: The opcode fields are class = bits [2:0] (7 = 64-bit class, 4 = 32-bit class), operand select = bit 3 (0 = immediate, 1 = source register) and operation = bits [7:4] (add 0, sub 1, mul 2, div 3, or 4, and 5, lsh 6, rsh 7, neg 8, mod 9, xor 10, mov 11, arsh 12).
- R4: In the 64-bit class the immediate is sign-extended to 64 bits. In the 32-bit class only its 32 bits are used.
- R5: add, sub and mul give the low 64 bits (64-bit class) or the low 32 bits (32-bit class) of the true result, wrapping on overflow.
- R6: or, and and xor combine the two operands bit by bit, and mov copies the second operand.
- R7: The shift amount is the second operand masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class. lsh and rsh fill with zeros. arsh fills with the sign bit of the operand width (bit 63 or bit 31).
- R8: neg gives the bitwise complement of the destination operand, and the second operand has no effect on the result.
- R9: div and mod are unsigned. A division by zero gives 0. A modulo by zero returns the full 64-bit destination value unchanged.
- R10: Every 32-bit class operation uses only the low 32 bits of its operands and writes its result zero-extended, so bits [63:32] are 0 (the one exception is mod by zero, see R9).
- R11: An operation code of 13 to 15, or a class other than 4 or 7, sets `out_illegal` high with that beat's result, and the result equals the full destination value. Legal beats give `out_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_opcode | input | 8 | Decoded opcode: operation, operand select, class |
| in_dst | input | 64 | Current destination register value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | New destination value |
| out_illegal | output | 1 | Beat carried an unsupported opcode |

## Verification
The bench targets the places where the two widths part ways. It checks sign extension against zero extension of a negative immediate: a design that got this wrong would return 0x80000000 from a 64-bit mov. It checks carries and shifted-out bits leaking into bits [63:32] of a 32-bit result, and shift amounts above the width limit, which a design without the mask would turn into zero. It also checks the arithmetic shift sign fill at bit 31, unsigned division of an all-ones value, and the two divide-by-zero rules. Those rules differ on purpose, so a shared zero-divisor path would break one of them. Backpressure tests confirm that a stalled result is neither overwritten nor lost, and illegal opcodes must both raise the flag and leave the destination untouched.

// File: rtl/dwalu_pkg.sv
// Shared widths, opcode field encodings and operation codes for the
// dual-width ALU. Assumes a 64-bit datapath with a 32-bit half-width class.
package dwalu_pkg;
    localparam int XLEN   = 64;
    localparam int HLEN   = 32;
    localparam int IMM_W  = 32;
    localparam int OPC_W  = 8;
    localparam int SHW64  = $clog2(XLEN);
    localparam int SHW32  = $clog2(HLEN);

    localparam logic [2:0] CLS_W64 = 3'd7;
    localparam logic [2:0] CLS_W32 = 3'd4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_OR   = 4'd4,
        OP_AND  = 4'd5,
        OP_LSH  = 4'd6,
        OP_RSH  = 4'd7,
        OP_NEG  = 4'd8,
        OP_MOD  = 4'd9,
        OP_XOR  = 4'd10,
        OP_MOV  = 4'd11,
        OP_ARSH = 4'd12
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    wide;
        logic    use_reg;
        logic    legal;
    } alu_ctl_t;
endpackage

// File: rtl/dwalu_decode.sv
// Splits the 8-bit opcode into class, operand select and operation code,
// and flags opcodes the unit cannot execute. Purely combinational.
module dwalu_decode
    import dwalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_ctl_t         ctl
);
    logic [2:0] cls;
    logic [3:0] opf;

    // Field extraction and legality check
    always_comb begin
        cls         = opcode[2:0];
        opf         = opcode[7:4];
        ctl.op      = alu_op_e'(opf);
        ctl.wide    = (cls == CLS_W64);
        ctl.use_reg = opcode[3];
        ctl.legal   = ((cls == CLS_W64) || (cls == CLS_W32)) && (opf <= 4'd12);
    end
endmodule

// File: rtl/dwalu_operand.sv
// Builds the two working operands. In the 64-bit class the immediate is
// sign-extended. In the 32-bit class both operands are cut to their low
// half and zero-extended. Purely combinational.
module dwalu_operand
    import dwalu_pkg::*;
(
    input  alu_ctl_t         ctl,
    input  logic [XLEN-1:0]  dst,
    input  logic [XLEN-1:0]  src,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  opa,
    output logic [XLEN-1:0]  opb
);
    localparam int EXT_W = XLEN - IMM_W;
    localparam int PAD_W = XLEN - HLEN;

    logic [XLEN-1:0] imm_ext;

    // Width-dependent widening of the immediate
    always_comb begin
        if (ctl.wide) imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        else          imm_ext = {{EXT_W{1'b0}}, imm};
    end

    // Operand selection and half-width trimming
    always_comb begin
        if (ctl.wide) begin
            opa = dst;
            opb = ctl.use_reg ? src : imm_ext;
        end else begin
            opa = {{PAD_W{1'b0}}, dst[HLEN-1:0]};
            opb = ctl.use_reg ? {{PAD_W{1'b0}}, src[HLEN-1:0]}
                              : {{PAD_W{1'b0}}, imm_ext[HLEN-1:0]};
        end
    end
endmodule

// File: rtl/dwalu_exec.sv
// Computes the new destination value from the prepared operands. Assumes
// 32-bit class operands arrive zero-extended. Returns the raw destination
// for illegal opcodes and for modulo by zero.
module dwalu_exec
    import dwalu_pkg::*;
(
    input  alu_ctl_t        ctl,
    input  logic [XLEN-1:0] dst,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result
);
    localparam int PAD_W = XLEN - HLEN;

    logic [SHW64-1:0] shamt;
    logic [XLEN-1:0]  ars_w;
    logic [HLEN-1:0]  ars_h;
    logic [XLEN-1:0]  raw;
    logic             keep;
    logic             b_zero;

    // Shift amount masking and the two arithmetic right shifts
    always_comb begin
        shamt = ctl.wide ? opb[SHW64-1:0] : {1'b0, opb[SHW32-1:0]};
        ars_w = $signed(opa) >>> shamt;
        ars_h = $signed(opa[HLEN-1:0]) >>> opb[SHW32-1:0];
        b_zero = (opb == '0);
    end

    // Operation select
    always_comb begin
        raw  = '0;
        keep = 1'b0;
        unique case (ctl.op)
            OP_ADD:  raw = opa + opb;
            OP_SUB:  raw = opa - opb;
            OP_MUL:  raw = opa * opb;
            OP_DIV:  raw = b_zero ? '0 : opa / opb;
            OP_OR:   raw = opa | opb;
            OP_AND:  raw = opa & opb;
            OP_LSH:  raw = opa << shamt;
            OP_RSH:  raw = opa >> shamt;
            OP_NEG:  raw = ~opa;
            OP_MOD: begin
                keep = b_zero;
                raw  = b_zero ? '0 : opa % opb;
            end
            OP_XOR:  raw = opa ^ opb;
            OP_MOV:  raw = opb;
            OP_ARSH: raw = ctl.wide ? ars_w : {{PAD_W{1'b0}}, ars_h};
            default: keep = 1'b1;
        endcase
    end

    // Final width fix-up and pass-through
    always_comb begin
        if (keep || !ctl.legal) result = dst;
        else if (ctl.wide)      result = raw;
        else                    result = {{PAD_W{1'b0}}, raw[HLEN-1:0]};
    end
endmodule

// File: rtl/dw_alu_unit.sv
// Top of the dual-width ALU. Decodes, prepares operands, computes, and
// holds the result in one output register behind a valid/ready handshake.
// Assumes the caller keeps in_* stable while in_valid is high and in_ready
// is low.
module dw_alu_unit
    import dwalu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OPC_W-1:0] in_opcode,
    input  logic [XLEN-1:0]  in_dst,
    input  logic [XLEN-1:0]  in_src,
    input  logic [IMM_W-1:0] in_imm,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [XLEN-1:0]  out_result,
    output logic             out_illegal
);
    alu_ctl_t        ctl;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] res_c;

    dwalu_decode u_dec (
        .opcode (in_opcode),
        .ctl    (ctl)
    );

    dwalu_operand u_opnd (
        .ctl (ctl),
        .dst (in_dst),
        .src (in_src),
        .imm (in_imm),
        .opa (opa),
        .opb (opb)
    );

    dwalu_exec u_exec (
        .ctl    (ctl),
        .dst    (in_dst),
        .opa    (opa),
        .opb    (opb),
        .result (res_c)
    );

    // Accept when the output slot is free or being drained
    assign in_ready = !out_valid || out_ready;

    // Output register with handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else if (in_ready) begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && !ctl.legal;
            if (in_valid) out_result <= res_c;
        end
    end
endmodule

// File: rtl/dwalu_checker.sv
// Protocol and datapath properties for dw_alu_unit, attached by bind.
module dwalu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  in_opcode,
    input logic [63:0] in_dst,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_result,
    input logic        out_illegal
);
    logic take;
    assign take = in_valid && in_ready;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_illegal); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R2

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R2

    AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid); // R2

    AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_opcode[2:0] == 3'd4 && in_opcode[7:4] <= 4'd12 && in_opcode[7:4] != 4'd9
        |=> out_result[63:32] == 32'h0); // R10

    AST_NEG_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_opcode[7:4] == 4'd8 && in_opcode[2:0] == 3'd7
        |=> out_result == ~$past(in_dst)); // R8

    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_opcode[7:4] > 4'd12
        |=> out_illegal && out_result == $past(in_dst)); // R11

    AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid); // R11
endmodule

bind dw_alu_unit dwalu_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_opcode   (in_opcode),
    .in_dst      (in_dst),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/dw_alu_unit_bench.sv
`timescale 1ns/1ps
module dw_alu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_opcode = 8'h0;
    logic [63:0] in_dst = '0;
    logic [63:0] in_src = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dw_alu_unit u_dw_alu_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .out_illegal(out_illegal)
    );

    // {opcode, dst, src, imm, expected result, expected illegal, req tag}
    localparam int NVEC = 28;
    localparam logic [232:0] VEC [NVEC] = '{
        {8'h07, 64'd10, 64'd0, 32'hFFFFFFFF, 64'd9, 1'b0},                                  // R4 R5
        {8'h04, 64'hFFFFFFFFFFFFFFFF, 64'd0, 32'd1, 64'd0, 1'b0},                           // R10
        {8'h1F, 64'd5, 64'd7, 32'd0, 64'hFFFFFFFFFFFFFFFE, 1'b0},                           // R5
        {8'h1C, 64'h0000000100000005, 64'd7, 32'd0, 64'h00000000FFFFFFFE, 1'b0},            // R10
        {8'h2F, 64'h0000000100000000, 64'h0000000100000000, 32'd0, 64'd0, 1'b0},            // R5
        {8'h24, 64'h0000000000012345, 64'd0, 32'h10, 64'h0000000000123450, 1'b0},           // R5
        {8'h3F, 64'd100, 64'd7, 32'd0, 64'd14, 1'b0},                                       // R9
        {8'h3F, 64'd100, 64'd0, 32'd0, 64'd0, 1'b0},                                        // R9
        {8'h37, 64'hFFFFFFFFFFFFFFFF, 64'd0, 32'd2, 64'h7FFFFFFFFFFFFFFF, 1'b0},            // R9
        {8'h9F, 64'd100, 64'd7, 32'd0, 64'd2, 1'b0},                                        // R9
        {8'h9C, 64'hAAAA555512345678, 64'hFFFFFFFF00000000, 32'd0, 64'hAAAA555512345678, 1'b0}, // R9
        {8'h47, 64'hF0, 64'd0, 32'h0F, 64'hFF, 1'b0},                                       // R6
        {8'h57, 64'h123456789ABCDEF0, 64'd0, 32'h80000000, 64'h1234567880000000, 1'b0},     // R4
        {8'hAC, 64'hFFFF00000000FFFF, 64'h00000000FFFFFFFF, 32'd0, 64'h00000000FFFF0000, 1'b0}, // R6
        {8'hB7, 64'd0, 64'd0, 32'h80000000, 64'hFFFFFFFF80000000, 1'b0},                    // R4
        {8'hB4, 64'h5555, 64'd0, 32'h80000000, 64'h0000000080000000, 1'b0},                 // R4
        {8'h67, 64'd1, 64'd0, 32'h41, 64'd2, 1'b0},                                         // R7
        {8'h64, 64'h0000000080000001, 64'd0, 32'h21, 64'd2, 1'b0},                          // R7
        {8'h7F, 64'h8000000000000000, 64'd63, 32'd0, 64'd1, 1'b0},                          // R7
        {8'hC7, 64'h8000000000000000, 64'd0, 32'd4, 64'hF800000000000000, 1'b0},            // R7
        {8'hCC, 64'h0000000080000000, 64'h24, 32'd0, 64'h00000000F8000000, 1'b0},           // R7
        {8'h74, 64'hFFFFFFFF80000000, 64'd0, 32'd4, 64'h0000000008000000, 1'b0},            // R7
        {8'h8F, 64'h00FF, 64'h1234, 32'd0, 64'hFFFFFFFFFFFFFF00, 1'b0},                     // R8
        {8'h84, 64'h123456780000FFFF, 64'd0, 32'h1234, 64'h00000000FFFF0000, 1'b0},         // R8
        {8'hD7, 64'hDEAD, 64'd1, 32'd1, 64'hDEAD, 1'b1},                                    // R11
        {8'h05, 64'h77, 64'd1, 32'd1, 64'h77, 1'b1},                                        // R11
        {8'hFC, 64'h1, 64'd1, 32'd1, 64'h1, 1'b1},                                          // R11
        {8'h0F, 64'd3, 64'd4, 32'd0, 64'd7, 1'b0}                                           // R3 R11
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im);
        in_opcode = op; in_dst = d; in_src = s; in_imm = im; in_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 out_illegal", {63'd0, out_illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready", {63'd0, in_ready}, 64'd1);

        // Table walk, one beat at a time (R3..R11)
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][232:225], VEC[i][224:161], VEC[i][160:97], VEC[i][96:65]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R2 valid vec%0d", i), {63'd0, out_valid}, 64'd1);
            check($sformatf("R3-table result vec%0d", i), out_result, VEC[i][64:1]);
            check($sformatf("R11 flag vec%0d", i), {63'd0, out_illegal}, {63'd0, VEC[i][0]});
        end

        // R2: backpressure holds result, blocks input, then resumes
        @(negedge clk);
        out_ready = 1'b0;
        drive(8'h07, 64'd1, 64'd0, 32'd1);          // add64 -> 2
        @(negedge clk);
        drive(8'hD7, 64'hBEEF, 64'd0, 32'd0);       // illegal, waits
        check("R2 stall in_ready", {63'd0, in_ready}, 64'd0);
        repeat (2) @(negedge clk);
        check("R2 stall result", out_result, 64'd2);
        check("R2 stall flag", {63'd0, out_illegal}, 64'd0);
        check("R2 stall valid", {63'd0, out_valid}, 64'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 resume result", out_result, 64'hBEEF);
        check("R11 resume flag", {63'd0, out_illegal}, 64'd1);
        @(negedge clk);
        check("R2 drain valid", {63'd0, out_valid}, 64'd0);
        check("R11 flag drops", {63'd0, out_illegal}, 64'd0);

        // R1: reset while holding a result
        out_ready = 1'b0;
        drive(8'hB7, 64'd0, 64'd0, 32'd9);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule